// File: doc/BRIEF.md
# Converter Output FIFO with Bypass

This block sits between the result register of an analogue-to-digital converter and the output register. Each result word is 18 bits wide. Bits [15:0] hold the conversion value, bit 16 holds a copy of the top bit, and bit 17 holds the overflow flag. The block stores the words as they are and does not interpret them.

When `buf_mode` is high, every finished conversion is written into a 16-word first-word-fall-through store. The end of a conversion is the falling edge of `conv_busy`. The oldest unread word is shown on `out_word` without any read. Each rising edge of `rd_strobe` moves the next word to the output. When `buf_mode` is low, the store is bypassed and `out_word` shows the newest conversion.

Two registered status bits report the fill level. Holding `buf_mode` and `rd_strobe` low together empties the store. All control inputs are asynchronous. They are synchronised to `clk` before use. `conv_result` must be stable around the falling edge of `conv_busy`.

Top module: `conv_fifo`

## Requirements
- R1: After system reset, `out_word` is zero and {`stat_hi`,`stat_lo`} is 01.
- R2: A word written into an empty store appears on `out_word` with no read edge.
- R3: Each rising edge of `rd_strobe` in buffered mode presents the next-oldest word. After 16 writes, 15 edges present words 2 to 16 in order.
- R4: A write made while 16 words are held is discarded. Later writes are also discarded until space exists. The output does not change.
- R5: A read edge when no word is held leaves `out_word` unchanged. A read that takes the count from 1 to 0 also leaves `out_word` unchanged and gives status 01.
- R6: {`stat_hi`,`stat_lo`} encodes the number of words held:
  - 01 for 0 words
  - 00 for 1 to 7 words
  - 10 for 8 to 15 words
  - 11 for 16 words
- R7: With `buf_mode`=0, `out_word` shows the newest conversion. Stored words and their count are untouched, and reappear when `buf_mode` returns to 1.
- R8: `buf_mode`=0 together with `rd_strobe`=0 empties the store, and the status then reads 01.
- R9: In buffered mode a conversion is written whatever the level of `rd_strobe`.
- R10: `out_word` changes on the third rising clock edge after the falling edge of `conv_busy`. The status changes on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| buf_mode | input | 1 | 1 = buffered path, 0 = direct path (asynchronous) |
| conv_busy | input | 1 | High while converting; its falling edge writes a result (asynchronous) |
| rd_strobe | input | 1 | Read strobe, idles high; a rising edge advances the output (asynchronous) |
| conv_result | input | 18 | Result word: [15:0] value, [16] top-bit copy, [17] overflow |
| out_word | output | 18 | Head of the store, or the newest result in direct mode |
| stat_hi | output | 1 | Fill status, upper bit |
| stat_lo | output | 1 | Fill status, lower bit |

## Verification
Each control input passes through two synchroniser flops and one edge register.

| Event | Result | Due on |
|---|---|---|
| Write or read edge | `out_word` changes | 3rd rising clock edge after the input changes |
| Write or read edge | Status changes | 4th rising clock edge after the input changes |
| Mode switch | Output mux follows | 2nd rising clock edge |

The bench drives inputs on falling clock edges. It normally waits six cycles after a stimulus before it samples. For the R10 check it samples on the falling edge just before and just after each due edge, so a one-cycle shift in either path is caught.

// File: rtl/conv_fifo_pkg.sv
// Shared constants and types for the converter output FIFO.
// Assumes a word of 16 value bits plus top-bit copy and overflow bits.
package conv_fifo_pkg;
    localparam int WORD_W = 18;
    typedef logic [WORD_W-1:0] word_t;
    // Status codes {hi,lo}
    localparam logic [1:0] ST_EMPTY = 2'b01;
    localparam logic [1:0] ST_LOW   = 2'b00;
    localparam logic [1:0] ST_HIGH  = 2'b10;
    localparam logic [1:0] ST_FULL  = 2'b11;
endpackage

// File: rtl/cf_sync.sv
// Multi-bit level synchroniser: each bit passes through STAGES flops.
// Assumes bits are independent, slow-changing levels.
module cf_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= rst_val;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cf_edge.sv
// Single-cycle pulse on one edge of a synchronised level.
// RISING selects the rising (1) or falling (0) edge variant.
module cf_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_val,
    input  logic lvl,
    output logic pulse
);
    logic prev;

    // Remember the level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= rst_val;
        else        prev <= lvl;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = lvl & ~prev;
        end else begin : g_fall
            assign pulse = ~lvl & prev;
        end
    endgenerate
endmodule

// File: rtl/cf_store.sv
// First-word-fall-through storage with pointers and occupancy count.
// The head register holds the oldest unread word; a read with one word
// left empties the store but keeps the head. Writes when full are dropped.
// Assumes DEPTH is a power of two.
module cf_store
    import conv_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic                       clr,
    input  word_t                      din,
    output word_t                      head,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    word_t         mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          wr_ok, rd_ok;

    assign wr_ok = wr_en && (count < FULL_CNT);
    assign rd_ok = rd_en && (count != '0);

    // Write accepted words into the array.
    always_ff @(posedge clk) begin
        if (wr_ok && !clr) mem[wptr] <= din;
    end

    // Advance pointers and occupancy; pin clear empties the store.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (rd_ok) rptr <= rptr + 1'b1;
            count <= count + (AW+1)'(wr_ok) - (AW+1)'(rd_ok);
        end
    end

    // Update the head word: fall-through on first write, next word on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
        end else if (!clr) begin
            if (wr_ok && (count == '0 || (rd_ok && count == 1)))
                head <= din;
            else if (rd_ok && count >= 2)
                head <= mem[rptr + 1'b1];
        end
    end

    a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && wr_en && !rd_en && !clr) |=> (count == FULL_CNT && $stable(head)));
    a_r5_empty_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && rd_en && !wr_en && !clr) |=> (count == '0 && $stable(head)));
    a_r2_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && wr_en && !clr) |=> (head == $past(din)));
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);
endmodule

// File: rtl/cf_status.sv
// Registered two-bit fill status derived only from the occupancy count.
module cf_status
    import conv_fifo_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [$clog2(DEPTH):0] count,
    output logic                   stat_hi,
    output logic                   stat_lo
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [1:0] code;

    // Encode the fill level.
    always_comb begin
        if (count == '0)       code = ST_EMPTY;
        else if (count < HALF) code = ST_LOW;
        else if (count < FULL) code = ST_HIGH;
        else                   code = ST_FULL;
    end

    // Register the status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) {stat_hi, stat_lo} <= ST_EMPTY;
        else        {stat_hi, stat_lo} <= code;
    end

    a_r6_empty_code: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |=> ({stat_hi, stat_lo} == ST_EMPTY));
    a_r6_full_code: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL) |=> ({stat_hi, stat_lo} == ST_FULL));
endmodule

// File: rtl/conv_fifo.sv
// Converter output FIFO with bypass. Synchronises the mode, read and
// end-of-conversion inputs, routes writes/reads to the store in buffered
// mode, keeps a direct register for bypass mode, and muxes the output.
// Assumes conv_result is stable around the falling edge of conv_busy.
module conv_fifo
    import conv_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_mode,
    input  logic              conv_busy,
    input  logic              rd_strobe,
    input  logic [WORD_W-1:0] conv_result,
    output logic [WORD_W-1:0] out_word,
    output logic              stat_hi,
    output logic              stat_lo
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic          mode_s, busy_s, rd_s;
    logic          done_p, rd_p;
    logic          wr_en, rd_en, clr;
    logic [CW-1:0] count_w;
    word_t         head_w, direct_q;

    cf_sync #(.WIDTH(3), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .rst_val(3'b101),
        .d({buf_mode, conv_busy, rd_strobe}),
        .q({mode_s, busy_s, rd_s})
    );

    cf_edge #(.RISING(1'b0)) u_done (
        .clk(clk), .rst_n(rst_n), .rst_val(1'b0), .lvl(busy_s), .pulse(done_p)
    );

    cf_edge #(.RISING(1'b1)) u_rd (
        .clk(clk), .rst_n(rst_n), .rst_val(1'b1), .lvl(rd_s), .pulse(rd_p)
    );

    assign wr_en = done_p && mode_s;
    assign rd_en = rd_p && mode_s;
    assign clr   = !mode_s && !rd_s;

    cf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .clr(clr),
        .din(conv_result), .head(head_w), .count(count_w)
    );

    cf_status #(.DEPTH(DEPTH)) u_status (
        .clk(clk), .rst_n(rst_n), .count(count_w),
        .stat_hi(stat_hi), .stat_lo(stat_lo)
    );

    // Capture the newest conversion for the direct path.
    always_ff @(posedge clk) begin
        if (!rst_n)                direct_q <= '0;
        else if (done_p && !mode_s) direct_q <= conv_result;
    end

    assign out_word = mode_s ? head_w : direct_q;

    a_r7_direct_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_s && rd_s) |=> (count_w == $past(count_w)));
    a_r8_pin_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_s && !rd_s) |=> (count_w == '0));
endmodule

// File: tb/tb_conv_fifo.sv
`timescale 1ns/1ps
module tb_conv_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        buf_mode = 1'b1;
    logic        conv_busy = 1'b0;
    logic        rd_strobe = 1'b1;
    logic [17:0] conv_result = '0;
    logic [17:0] out_word;
    logic        stat_hi, stat_lo;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    conv_fifo dut (
        .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode), .conv_busy(conv_busy),
        .rd_strobe(rd_strobe), .conv_result(conv_result),
        .out_word(out_word), .stat_hi(stat_hi), .stat_lo(stat_lo)
    );

    function automatic logic [17:0] pat(int i);
        return 18'((i * 31987 + 74565) ^ (i << 13));
    endfunction

    function automatic logic [1:0] exp_stat(int n);
        if (n == 0)      return 2'b01;
        else if (n < 8)  return 2'b00;
        else if (n < 16) return 2'b10;
        else             return 2'b11;
    endfunction

    task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic conv(logic [17:0] w);
        conv_result = w;
        conv_busy = 1'b1;
        cyc(3);
        conv_busy = 1'b0;
        cyc(6);
    endtask

    task automatic rd_pulse();
        rd_strobe = 1'b0;
        cyc(3);
        rd_strobe = 1'b1;
        cyc(6);
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(5);
        // R1 reset state
        chk("R1 out", out_word, 18'h0);
        chk("R1 stat", {16'h0, stat_hi, stat_lo}, {16'h0, 2'b01});
        rst_n = 1'b1;
        cyc(4);

        // R2/R6 fill sweep: head stays word 1, status tracks count
        for (int i = 1; i <= 16; i++) begin
            conv(pat(i));
            chk("R2 head", out_word, pat(1));
            chk("R6 stat fill", {16'h0, stat_hi, stat_lo}, {16'h0, exp_stat(i)});
        end

        // R4 writes while full are dropped
        conv(pat(17));
        conv(pat(18));
        chk("R4 head", out_word, pat(1));
        chk("R4 stat", {16'h0, stat_hi, stat_lo}, {16'h0, 2'b11});

        // R3/R6 drain with 15 read edges
        for (int k = 2; k <= 16; k++) begin
            rd_pulse();
            chk("R3 word", out_word, pat(k));
            chk("R6 stat drain", {16'h0, stat_hi, stat_lo}, {16'h0, exp_stat(17 - k)});
        end

        // R5 last read empties, head kept; extra read changes nothing
        rd_pulse();
        chk("R5 last", out_word, pat(16));
        chk("R5 stat", {16'h0, stat_hi, stat_lo}, {16'h0, 2'b01});
        rd_pulse();
        chk("R5 extra", out_word, pat(16));
        chk("R5 extra stat", {16'h0, stat_hi, stat_lo}, {16'h0, 2'b01});

        // R9 write while the read strobe is held low
        rd_strobe = 1'b0;
        cyc(3);
        conv(pat(20));
        chk("R9 head", out_word, pat(20));
        chk("R9 stat", {16'h0, stat_hi, stat_lo}, {16'h0, 2'b00});
        rd_strobe = 1'b1;
        cyc(6);
        chk("R5 one to zero", out_word, pat(20));
        chk("R5 one to zero stat", {16'h0, stat_hi, stat_lo}, {16'h0, 2'b01});

        // R7 direct mode bypasses and leaves the store alone
        conv(pat(21));
        conv(pat(22));
        conv(pat(23));
        buf_mode = 1'b0;
        cyc(4);
        conv(pat(30));
        chk("R7 direct", out_word, pat(30));
        chk("R7 stat held", {16'h0, stat_hi, stat_lo}, {16'h0, 2'b00});
        buf_mode = 1'b1;
        cyc(4);
        chk("R7 head back", out_word, pat(21));
        rd_pulse();
        chk("R7 next", out_word, pat(22));
        rd_pulse();
        chk("R7 third", out_word, pat(23));
        chk("R7 stat", {16'h0, stat_hi, stat_lo}, {16'h0, 2'b00});

        // R8 pin combination clears the store
        buf_mode = 1'b0;
        cyc(4);
        rd_strobe = 1'b0;
        cyc(4);
        rd_strobe = 1'b1;
        cyc(4);
        buf_mode = 1'b1;
        cyc(6);
        chk("R8 stat", {16'h0, stat_hi, stat_lo}, {16'h0, 2'b01});

        // R10 latency of output and status after the conversion ends
        conv_result = pat(40);
        conv_busy = 1'b1;
        cyc(3);
        conv_busy = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R10 out before", out_word, pat(23));
        @(posedge clk);
        @(negedge clk);
        chk("R10 out due", out_word, pat(40));
        chk("R10 stat before", {16'h0, stat_hi, stat_lo}, {16'h0, 2'b01});
        @(posedge clk);
        @(negedge clk);
        chk("R10 stat due", {16'h0, stat_hi, stat_lo}, {16'h0, 2'b00});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule